// File: doc/BRIEF.md
# Remote Terminal Descriptor Buffer Manager

This block sits beside the protocol engine of a serial-bus remote terminal. Once a command has been decoded, it takes the command fields and finds the four-word descriptor block for that command in a shared RAM table. It reads the four words through a one-cycle-latency synchronous RAM port. From the buffer mode in the block's Control Word it works out where the message data lives, and it presents that start address until the message engine reports that the message has finished.

It then writes the descriptor back. The Control Word always gets its access flag. A ping-pong descriptor also toggles its pointer-select bit. An indexed descriptor gets its advanced pointer and its decremented message count. A one-cycle message interrupt request can follow the write-back. A base register, loaded from a write strobe, places the whole table anywhere in the RAM address space.

Top module: `rt_desc_mgr`

## Requirements
- R1: After reset `buf_valid`, `irq` and `unsup_mode` are 0, no RAM access is made, and the table base is 0x0400.
- R2: The table has four regions relative to the base. Receive subaddress blocks start at +0x000 and transmit subaddress blocks at +0x080. Receive mode-code blocks start at +0x100 and transmit mode-code blocks at +0x180. Each block's word k (k = 0..3) is at region start + 4 × number + k. Word 0 is the Control Word. `buf_addr` holds steady while `buf_valid` is high.
- R3: A subaddress field of 0 or 31 marks a mode-code command, and its 5-bit count field then gives the block number. Such a message moves 1 data word when the mode code is 16 or above, and 0 words otherwise.
- R4: Control Word bits 2:0 = 100 selects ping-pong mode. `buf_addr` is word 2 when Control bit 4 (pointer select) is 1, and word 1 when it is 0. Bit 4 toggles in the written-back Control Word only after a good message.
- R5: Control bits 2:0 = 000 selects index mode. `buf_addr` is word 1 (pointer). After a good message with word 2 (count) non-zero, the pointer is written back increased by 2 + N and the count decreased by 1. N is the count field for subaddress commands, with a field of 0 meaning 32.
- R6: In index mode with a count of 0, a good message leaves both pointer and count unchanged in RAM, so every later message gets the same buffer address.
- R7: For a receive broadcast with `notice2_en` high, `buf_addr` is word 3. Neither the pointer-select bit, the pointer nor the count is changed. With `notice2_en` low, a broadcast uses the normal pointer.
- R8: Every completed message writes Control bit 15 (access flag) to 1. A message with `msg_good` low changes nothing else in the block, and its only write is to word 0.
- R9: `irq` pulses for exactly one cycle after the write-back when `irq_en` is high and either Control bit 14 is set or an index count has just gone from 1 to 0. Otherwise `irq` stays low.
- R10: Any mode encoding other than 000 or 100 is handled as index mode and sets `unsup_mode`, which stays set until reset.
- R11: A pulse on `base_wr` loads `base_wdata` as the table base, and all later block addresses are offset from the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Load strobe for the table base |
| base_wdata | input | 16 | New table base |
| cmd_valid | input | 1 | Decoded command present (accepted when idle) |
| cmd_tx | input | 1 | 1 = transmit command |
| cmd_sa | input | 5 | Subaddress field |
| cmd_wc | input | 5 | Word count / mode code field |
| cmd_bcast | input | 1 | Command was broadcast |
| notice2_en | input | 1 | Separate broadcast receive storage enabled |
| irq_en | input | 1 | Message interrupt enable |
| msg_done | input | 1 | Message finished (sampled while `buf_valid`) |
| msg_good | input | 1 | Finished message had no error |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write (read when 0) |
| ram_addr | output | 16 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after a read |
| buf_valid | output | 1 | `buf_addr` is valid |
| buf_addr | output | 16 | Data buffer start address |
| irq | output | 1 | One-cycle message interrupt request |
| unsup_mode | output | 1 | Sticky: an unsupported buffer mode was seen |

## Verification
The bench checks that ping-pong selection alternates only on good messages. A design that toggled on failed messages would hand the same buffer out twice in a row. It drives an index descriptor down through the 1-to-0 count step and then past zero. A design that kept advancing would walk off its buffer, and one that missed the step would lose the buffer-full interrupt. Mode-code numbering, the 32-word encoding of a zero count and Notice II broadcast redirection are covered with exact addresses, because any error there points a buffer at the wrong block or moves a pointer by the wrong step. Failed messages, unsupported encodings and a relocated base are also checked in RAM, so a stray write or a missed offset shows up directly.

// File: rtl/rt_desc_pkg.sv
package rt_desc_pkg;
   localparam int unsigned BLK_WORDS = 4;
   localparam int unsigned BLK_SHIFT = 2;
   localparam int unsigned REGION_SHIFT = 7;
   localparam int unsigned DBAC_BIT = 15;
   localparam int unsigned IWA_BIT = 14;
   localparam logic [2:0] MODE_PP = 3'b100;
   localparam logic [2:0] MODE_IDX = 3'b000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_CAP,
      ST_BUF,
      ST_WR,
      ST_FIN
   } dm_state_t;
endpackage

// File: rtl/rt_desc_addr.sv
module rt_desc_addr
   import rt_desc_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input  logic [AW-1:0] base,
   input  logic          tx,
   input  logic [4:0]    sa,
   input  logic [4:0]    wc,
   output logic [AW-1:0] blk_addr,
   output logic [5:0]    nwords
);
   logic          is_mc;
   logic [4:0]    num;
   logic [AW-1:0] region_off;
   logic [AW-1:0] blk_off;

   always_comb begin
      is_mc      = (sa == 5'd0) || (sa == 5'd31);
      num        = is_mc ? wc : sa;
      region_off = AW'({is_mc, tx}) << REGION_SHIFT;
      blk_off    = AW'(num) << BLK_SHIFT;
      blk_addr   = base + region_off + blk_off;
      if (is_mc)
         nwords = {5'd0, wc[4]};
      else if (wc == 5'd0)
         nwords = 6'd32;
      else
         nwords = {1'b0, wc};
   end
endmodule

// File: rtl/rt_desc_upd.sv
module rt_desc_upd
   import rt_desc_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned DPB_BIT = 4
) (
   input  logic [DW-1:0] ctrl,
   input  logic [DW-1:0] wa,
   input  logic [DW-1:0] wb,
   input  logic [DW-1:0] wbc,
   input  logic          good,
   input  logic          use_bc,
   input  logic [5:0]    nwords,
   output logic [DW-1:0] sel_ptr,
   output logic [DW-1:0] new_ctrl,
   output logic [DW-1:0] new_ptr,
   output logic [DW-1:0] new_cnt,
   output logic          wr_ptr,
   output logic          full,
   output logic          unsup
);
   logic [2:0] mode;
   logic       is_pp;

   always_comb begin
      mode    = ctrl[2:0];
      is_pp   = (mode == MODE_PP);
      unsup   = !is_pp && (mode != MODE_IDX);
      if (use_bc)
         sel_ptr = wbc;
      else if (is_pp && ctrl[DPB_BIT])
         sel_ptr = wb;
      else
         sel_ptr = wa;
      new_ctrl = ctrl;
      new_ctrl[DBAC_BIT] = 1'b1;
      if (is_pp && good && !use_bc)
         new_ctrl[DPB_BIT] = !ctrl[DPB_BIT];
      wr_ptr  = !is_pp && good && !use_bc && (wb != '0);
      new_ptr = wa + DW'(nwords) + DW'(2);
      new_cnt = wb - DW'(1);
      full    = wr_ptr && (wb == DW'(1));
   end
endmodule

// File: rtl/rt_desc_mgr.sv
module rt_desc_mgr
   import rt_desc_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 16,
   parameter logic [AW-1:0] DEF_BASE = 'h0400,
   parameter int unsigned DPB_BIT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_wr,
   input  logic [AW-1:0] base_wdata,
   input  logic          cmd_valid,
   input  logic          cmd_tx,
   input  logic [4:0]    cmd_sa,
   input  logic [4:0]    cmd_wc,
   input  logic          cmd_bcast,
   input  logic          notice2_en,
   input  logic          irq_en,
   input  logic          msg_done,
   input  logic          msg_good,
   output logic          ram_en,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   input  logic [DW-1:0] ram_rdata,
   output logic          buf_valid,
   output logic [AW-1:0] buf_addr,
   output logic          irq,
   output logic          unsup_mode
);
   localparam int unsigned NW = BLK_WORDS;
   localparam int unsigned IW = $clog2(NW);

   generate
      if (AW > DW || AW < 10) begin : g_bad_aw
         $error("rt_desc_mgr: AW must be 10..DW");
      end
      if (DW < 16 || DPB_BIT < 3 || DPB_BIT >= IWA_BIT) begin : g_bad_dw
         $error("rt_desc_mgr: DW must be >= 16 and DPB_BIT in 3..13");
      end
   endgenerate

   dm_state_t     st;
   logic [IW-1:0] idx;
   logic          cap_vld;
   logic [IW-1:0] cap_idx;
   logic [DW-1:0] words [NW];
   logic [AW-1:0] base_q;
   logic [AW-1:0] blk_q;
   logic [5:0]    nwords_q;
   logic          use_bc_q;
   logic          good_q;
   logic          unsup_q;

   logic [AW-1:0] a_blk;
   logic [5:0]    a_nwords;
   logic [DW-1:0] u_sel, u_ctrl, u_ptr, u_cnt;
   logic          u_wr_ptr, u_full, u_unsup;
   logic          wr_last;

   rt_desc_addr #(.AW(AW)) u_addr (
      .base     (base_q),
      .tx       (cmd_tx),
      .sa       (cmd_sa),
      .wc       (cmd_wc),
      .blk_addr (a_blk),
      .nwords   (a_nwords)
   );

   rt_desc_upd #(.DW(DW), .DPB_BIT(DPB_BIT)) u_upd (
      .ctrl     (words[0]),
      .wa       (words[1]),
      .wb       (words[2]),
      .wbc      (words[3]),
      .good     (good_q),
      .use_bc   (use_bc_q),
      .nwords   (nwords_q),
      .sel_ptr  (u_sel),
      .new_ctrl (u_ctrl),
      .new_ptr  (u_ptr),
      .new_cnt  (u_cnt),
      .wr_ptr   (u_wr_ptr),
      .full     (u_full),
      .unsup    (u_unsup)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= DEF_BASE;
      else if (base_wr)
         base_q <= base_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_vld <= 1'b0;
         cap_idx <= '0;
         for (int i = 0; i < NW; i++) words[i] <= '0;
      end else begin
         cap_vld <= (st == ST_RD);
         cap_idx <= idx;
         if (cap_vld) words[cap_idx] <= ram_rdata;
      end
   end

   assign wr_last = ((idx == '0) && !u_wr_ptr) || (idx == IW'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         idx      <= '0;
         blk_q    <= '0;
         nwords_q <= '0;
         use_bc_q <= 1'b0;
         good_q   <= 1'b0;
         unsup_q  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (cmd_valid) begin
               blk_q    <= a_blk;
               nwords_q <= a_nwords;
               use_bc_q <= cmd_bcast && !cmd_tx && notice2_en;
               idx      <= '0;
               st       <= ST_RD;
            end
            ST_RD: begin
               idx <= idx + IW'(1);
               if (idx == IW'(NW - 1)) st <= ST_CAP;
            end
            ST_CAP: st <= ST_BUF;
            ST_BUF: begin
               if (u_unsup) unsup_q <= 1'b1;
               if (msg_done) begin
                  good_q <= msg_good;
                  idx    <= '0;
                  st     <= ST_WR;
               end
            end
            ST_WR: begin
               if (wr_last) st <= ST_FIN;
               else idx <= idx + IW'(1);
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ram_en   = (st == ST_RD) || (st == ST_WR);
      ram_we   = (st == ST_WR);
      ram_addr = blk_q + AW'(idx);
      case (idx)
         IW'(0):  ram_wdata = u_ctrl;
         IW'(1):  ram_wdata = u_ptr;
         default: ram_wdata = u_cnt;
      endcase
      buf_valid  = (st == ST_BUF);
      buf_addr   = u_sel[AW-1:0];
      irq        = (st == ST_FIN) && irq_en && (words[0][IWA_BIT] || u_full);
      unsup_mode = unsup_q;
   end

   // R9: the interrupt request is a single-cycle pulse
   p_irq_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R2: buffer address held while waiting for the end of the message
   p_buf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && !msg_done) |=> (buf_valid && $stable(buf_addr)));

   // R10: unsupported-mode flag never clears
   p_unsup_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_mode |=> unsup_mode);

   // R8: writes stay inside the first three words of the block
   p_write_in_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ((ram_addr - blk_q) < AW'(3)));

   // R8: Control Word write-back always carries the access flag
   p_ctrl_dbac_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && (ram_addr == blk_q)) |-> ram_wdata[DBAC_BIT]);

   // R8: failed message writes only the Control Word
   p_fail_ctrl_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !good_q) |-> (ram_addr == blk_q));
endmodule

// File: tb/rt_desc_mgr_bench.sv
module rt_desc_mgr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_wr = 1'b0;
   logic [15:0] base_wdata = '0;
   logic        cmd_valid = 1'b0, cmd_tx = 1'b0, cmd_bcast = 1'b0;
   logic [4:0]  cmd_sa = '0, cmd_wc = '0;
   logic        notice2_en = 1'b0, irq_en = 1'b1;
   logic        msg_done = 1'b0, msg_good = 1'b0;
   logic        ram_en, ram_we;
   logic [15:0] ram_addr, ram_wdata;
   logic [15:0] ram_rdata = '0;
   logic        buf_valid, irq, unsup_mode;
   logic [15:0] buf_addr;

   logic [15:0] mem [0:4095];
   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;

   always #5 clk = ~clk;

   rt_desc_mgr u_rt_desc_mgr (
      .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
      .cmd_valid(cmd_valid), .cmd_tx(cmd_tx), .cmd_sa(cmd_sa), .cmd_wc(cmd_wc),
      .cmd_bcast(cmd_bcast), .notice2_en(notice2_en), .irq_en(irq_en),
      .msg_done(msg_done), .msg_good(msg_good), .ram_en(ram_en), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .buf_valid(buf_valid), .buf_addr(buf_addr), .irq(irq), .unsup_mode(unsup_mode)
   );

   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) mem[ram_addr[11:0]] <= ram_wdata;
         else ram_rdata <= mem[ram_addr[11:0]];
      end
      if (irq) irq_cnt <= irq_cnt + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic tx, input logic [4:0] sa, input logic [4:0] wc,
                       input logic bc, input logic n2, input logic good,
                       input logic [15:0] exp_buf, input string req);
      @(negedge clk);
      irq_cnt = 0;
      cmd_valid = 1'b1; cmd_tx = tx; cmd_sa = sa; cmd_wc = wc;
      cmd_bcast = bc; notice2_en = n2;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 40 && !buf_valid; i++) @(negedge clk);
      check({req, " buf_valid"}, int'(buf_valid), 1);
      check({req, " buf_addr"}, int'(buf_addr), int'(exp_buf));
      msg_done = 1'b1; msg_good = good;
      @(negedge clk);
      msg_done = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 buf_valid", int'(buf_valid), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 unsup_mode", int'(unsup_mode), 0);
      check("R1 ram_en", int'(ram_en), 0);
   endtask

   task automatic t_pingpong;
      mem[12'h404] = 16'h4004; mem[12'h405] = 16'h0100;
      mem[12'h406] = 16'h0200; mem[12'h407] = 16'h0600;
      send(1'b0, 5'd1, 5'd4, 1'b0, 1'b0, 1'b1, 16'h0100, "R4 R2 R1 first");
      check("R4 ctrl toggled", int'(mem[12'h404]), 16'hC014);
      check("R9 irq on IWA", irq_cnt, 1);
      send(1'b0, 5'd1, 5'd4, 1'b0, 1'b0, 1'b1, 16'h0200, "R4 second");
      check("R4 ctrl back", int'(mem[12'h404]), 16'hC004);
      check("R4 ptr A kept", int'(mem[12'h405]), 16'h0100);
   endtask

   task automatic t_fail;
      mem[12'h404] = 16'h4004;
      send(1'b0, 5'd1, 5'd4, 1'b0, 1'b0, 1'b0, 16'h0100, "R8 pp fail");
      check("R8 pp ctrl no toggle", int'(mem[12'h404]), 16'hC004);
      mem[12'h488] = 16'h0000; mem[12'h489] = 16'h0300; mem[12'h48A] = 16'h0002;
      send(1'b1, 5'd2, 5'd5, 1'b0, 1'b0, 1'b0, 16'h0300, "R8 idx fail");
      check("R8 idx ctrl", int'(mem[12'h488]), 16'h8000);
      check("R8 idx ptr kept", int'(mem[12'h489]), 16'h0300);
      check("R8 idx cnt kept", int'(mem[12'h48A]), 16'h0002);
   endtask

   task automatic t_index;
      mem[12'h488] = 16'h0000; mem[12'h489] = 16'h0300;
      mem[12'h48A] = 16'h0002; mem[12'h48B] = 16'h1234;
      send(1'b1, 5'd2, 5'd5, 1'b0, 1'b0, 1'b1, 16'h0300, "R5 idx 1");
      check("R5 ptr +7", int'(mem[12'h489]), 16'h0307);
      check("R5 cnt 1", int'(mem[12'h48A]), 16'h0001);
      check("R5 ctrl", int'(mem[12'h488]), 16'h8000);
      check("R9 no irq", irq_cnt, 0);
      send(1'b1, 5'd2, 5'd0, 1'b0, 1'b0, 1'b1, 16'h0307, "R5 idx 32w");
      check("R5 ptr +34", int'(mem[12'h489]), 16'h0329);
      check("R5 cnt 0", int'(mem[12'h48A]), 16'h0000);
      check("R9 full irq", irq_cnt, 1);
      send(1'b1, 5'd2, 5'd3, 1'b0, 1'b0, 1'b1, 16'h0329, "R6 idx zero");
      check("R6 ptr frozen", int'(mem[12'h489]), 16'h0329);
      check("R6 cnt frozen", int'(mem[12'h48A]), 16'h0000);
      check("R6 word3 untouched", int'(mem[12'h48B]), 16'h1234);
      check("R6 no irq", irq_cnt, 0);
      send(1'b1, 5'd2, 5'd3, 1'b0, 1'b0, 1'b1, 16'h0329, "R6 idx zero again");
   endtask

   task automatic t_modecode;
      mem[12'h5CC] = 16'h0000; mem[12'h5CD] = 16'h0500; mem[12'h5CE] = 16'h0004;
      send(1'b1, 5'd31, 5'd19, 1'b0, 1'b0, 1'b1, 16'h0500, "R3 tx mc19");
      check("R3 mc ptr +3", int'(mem[12'h5CD]), 16'h0503);
      check("R3 mc cnt", int'(mem[12'h5CE]), 16'h0003);
      mem[12'h508] = 16'h0000; mem[12'h509] = 16'h0520; mem[12'h50A] = 16'h0001;
      send(1'b0, 5'd0, 5'd2, 1'b0, 1'b0, 1'b1, 16'h0520, "R3 rx mc2");
      check("R3 mc ptr +2", int'(mem[12'h509]), 16'h0522);
      check("R3 R9 mc full irq", irq_cnt, 1);
   endtask

   task automatic t_notice2;
      mem[12'h40C] = 16'h0004; mem[12'h40D] = 16'h0100;
      mem[12'h40E] = 16'h0200; mem[12'h40F] = 16'h0600;
      send(1'b0, 5'd3, 5'd2, 1'b1, 1'b1, 1'b1, 16'h0600, "R7 bcast n2");
      check("R7 no toggle", int'(mem[12'h40C]), 16'h8004);
      send(1'b0, 5'd3, 5'd2, 1'b1, 1'b0, 1'b1, 16'h0100, "R7 bcast no n2");
      check("R7 toggle", int'(mem[12'h40C]), 16'h8014);
      mem[12'h418] = 16'h0000; mem[12'h419] = 16'h0700;
      mem[12'h41A] = 16'h0003; mem[12'h41B] = 16'h0650;
      send(1'b0, 5'd6, 5'd2, 1'b1, 1'b1, 1'b1, 16'h0650, "R7 idx bcast");
      check("R7 idx ptr kept", int'(mem[12'h419]), 16'h0700);
      check("R7 idx cnt kept", int'(mem[12'h41A]), 16'h0003);
      notice2_en = 1'b0;
   endtask

   task automatic t_unsup;
      check("R10 flag clear before", int'(unsup_mode), 0);
      mem[12'h414] = 16'h0001; mem[12'h415] = 16'h0780; mem[12'h416] = 16'h0001;
      send(1'b0, 5'd5, 5'd1, 1'b0, 1'b0, 1'b1, 16'h0780, "R10 circ as idx");
      check("R10 ptr", int'(mem[12'h415]), 16'h0783);
      check("R10 cnt", int'(mem[12'h416]), 16'h0000);
      check("R10 flag set", int'(unsup_mode), 1);
      mem[12'h404] = 16'h0004;
      send(1'b0, 5'd1, 5'd1, 1'b0, 1'b0, 1'b1, 16'h0100, "R10 later pp");
      check("R10 flag sticky", int'(unsup_mode), 1);
   endtask

   task automatic t_irq_mask;
      irq_en = 1'b0;
      mem[12'h404] = 16'h4004;
      send(1'b0, 5'd1, 5'd1, 1'b0, 1'b0, 1'b1, 16'h0100, "R9 masked");
      check("R9 masked no irq", irq_cnt, 0);
      irq_en = 1'b1;
      mem[12'h404] = 16'h0004;
      send(1'b0, 5'd1, 5'd1, 1'b0, 1'b0, 1'b1, 16'h0100, "R9 no IWA");
      check("R9 no IWA no irq", irq_cnt, 0);
   endtask

   task automatic t_base;
      mem[12'h804] = 16'h0004; mem[12'h805] = 16'h0111; mem[12'h806] = 16'h0222;
      mem[12'h404] = 16'h0004;
      @(negedge clk);
      base_wr = 1'b1; base_wdata = 16'h0800;
      @(negedge clk);
      base_wr = 1'b0;
      send(1'b0, 5'd1, 5'd1, 1'b0, 1'b0, 1'b1, 16'h0111, "R11 relocated");
      check("R11 new block written", int'(mem[12'h804]), 16'h8014);
      check("R11 old block untouched", int'(mem[12'h404]), 16'h0004);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_pingpong;
      t_fail;
      t_index;
      t_modecode;
      t_notice2;
      t_unsup;
      t_irq_mask;
      t_base;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule